// File: doc/BRIEF.md
# Pin Sense Detector with Sticky Latch

This block watches a port of input pins and raises a single detect line when any enabled pin is at its chosen active level. Each pin has a sense-enable bit and an invert bit. A pin is "detected" when its level, after the optional inversion, is high and its enable bit is set. The per-pin detected bits form a live vector. A sticky vector collects every bit that has been detected since software last cleared it.

Software reads the sticky vector on `sticky_o` and clears bits by writing ones on `clr_data` with `clr_we` high. A clear never removes a bit whose live detect is high in the same cycle. The `use_sticky` select picks the source of the detect line. When it is low, the line follows the live vector. When it is high, the line follows the sticky vector. Each low-to-high transition of the line produces a one-cycle event pulse. In sticky mode, a clear that still leaves bits set holds the line low for a fixed number of cycles and then lets it rise again, so a new event is produced for the bits that remain.

Top module: `pin_sense_detect`

## Requirements
- R1: The live detect bit of pin i is high when `(pin_level[i] XOR sense_inv[i]) AND sense_en[i]` is high. With `use_sticky`=0, `detect_o` shows the OR of the live bits one clock after the inputs are sampled.
- R2: Each clock, every live bit is ORed into the sticky vector, and `sticky_o` shows the result one clock later. A sticky bit stays set after its live bit falls, for as long as no clear removes it.
- R3: A write (`clr_we`=1) clears every sticky bit whose `clr_data` bit is 1 and whose live bit is low. Sticky bits whose `clr_data` bit is 0 are unchanged.
- R4: If a live bit is high in the same cycle as a clear that targets it, the sticky bit stays set. Set wins over clear.
- R5: With `use_sticky`=1, `detect_o` after a clock edge is the OR of the sticky vector registered at that same edge. With `use_sticky`=0, it is the OR of the live vector sampled at that edge.
- R6: `event_o` is high for exactly one cycle, in the cycle in which `detect_o` rises. This includes a rise caused only by a change of `use_sticky`.
- R7: In sticky mode, a write that has a 1 in `clr_data` and leaves the sticky vector nonzero forces `detect_o` low for REARM_LOW_CYCLES (default 2) cycles. After that window `detect_o` rises again and `event_o` pulses.
- R8: While reset is asserted and directly after it, `sticky_o` is zero, and `detect_o` and `event_o` are low.
- R9: A write with `clr_data` all zero changes neither the sticky vector nor `detect_o`. It also does not start the low window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NPINS | Synchronized pin input levels |
| sense_en | input | NPINS | Per-pin sense enable |
| sense_inv | input | NPINS | Per-pin polarity invert (1 = sense low level) |
| use_sticky | input | 1 | Detect line source: 0 = live vector, 1 = sticky vector |
| clr_we | input | 1 | Sticky-vector clear strobe |
| clr_data | input | NPINS | Write-one-to-clear mask for the sticky vector |
| detect_o | output | 1 | Port-level detect line |
| event_o | output | 1 | One-cycle pulse on each rise of detect_o |
| sticky_o | output | NPINS | Sticky vector readback |

## Verification
The bound checker checks several properties on every cycle. Every live bit appears in the sticky vector on the next cycle. Without a clear strobe, no sticky bit is ever lost. Each event pulse coincides with a rise of the detect line, and each rise carries one. A qualifying clear in sticky mode pulls the line low for the whole window. Only the bench scenarios show the exact values: the effect of the invert and enable masks, set-over-clear on a targeted bit, the all-zero write having no effect, the source switch between live and sticky vectors, and the re-rise with its fresh event after the low window ends.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STICKY = 1'b1
   } psd_src_e;

   function automatic int hold_width(input int cycles);
      return (cycles > 1) ? $clog2(cycles) : 1;
   endfunction

endpackage

// File: rtl/psd_sense_vec.sv
module psd_sense_vec #(
   parameter int NPINS = 8
) (
   input  logic [NPINS-1:0] pin_level,
   input  logic [NPINS-1:0] sense_en,
   input  logic [NPINS-1:0] sense_inv,
   output logic [NPINS-1:0] live
);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      always_comb begin
         live[i] = (pin_level[i] ^ sense_inv[i]) & sense_en[i];
      end
   end

endmodule

// File: rtl/psd_latch_bank.sv
module psd_latch_bank #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] live,
   input  logic             clr_we,
   input  logic [NPINS-1:0] clr_data,
   output logic [NPINS-1:0] sticky_q,
   output logic [NPINS-1:0] sticky_d
);

   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      logic wipe;

      always_comb begin
         wipe        = clr_we & clr_data[i];
         // set has priority: a live bit survives its own clear
         sticky_d[i] = (sticky_q[i] & ~wipe) | live[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sticky_q[i] <= 1'b0;
         else        sticky_q[i] <= sticky_d[i];
      end
   end

endmodule

// File: rtl/psd_detect_line.sv
module psd_detect_line
   import psd_pkg::*;
#(
   parameter int NPINS            = 8,
   parameter int REARM_LOW_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  psd_src_e         src_sel,
   input  logic [NPINS-1:0] live,
   input  logic [NPINS-1:0] sticky_d,
   input  logic             rearm_kick,
   output logic             detect_q,
   output logic             event_q
);

   localparam int HW = hold_width(REARM_LOW_CYCLES);

   logic src_level;
   logic holding;
   logic det_d;

   always_comb begin
      src_level = (src_sel == SRC_STICKY) ? |sticky_d : |live;
   end

   if (REARM_LOW_CYCLES == 1) begin : g_single
      // a one-cycle window needs nothing beyond the kick itself
      assign holding = 1'b0;
   end else begin : g_counter
      logic [HW-1:0] hold_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              hold_cnt <= '0;
         else if (rearm_kick)     hold_cnt <= HW'(REARM_LOW_CYCLES - 1);
         else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      end

      assign holding = (hold_cnt != '0);
   end

   always_comb begin
      det_d = src_level & ~rearm_kick & ~holding;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detect_q <= 1'b0;
         event_q  <= 1'b0;
      end else begin
         detect_q <= det_d;
         event_q  <= det_d & ~detect_q;
      end
   end

endmodule

// File: rtl/pin_sense_detect.sv
module pin_sense_detect
   import psd_pkg::*;
#(
   parameter int NPINS            = 8,
   parameter int REARM_LOW_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_level,
   input  logic [NPINS-1:0] sense_en,
   input  logic [NPINS-1:0] sense_inv,
   input  logic             use_sticky,
   input  logic             clr_we,
   input  logic [NPINS-1:0] clr_data,
   output logic             detect_o,
   output logic             event_o,
   output logic [NPINS-1:0] sticky_o
);

   if (NPINS < 1) begin : g_bad_npins
      $error("pin_sense_detect: NPINS must be at least 1");
   end
   if (REARM_LOW_CYCLES < 1) begin : g_bad_rearm
      $error("pin_sense_detect: REARM_LOW_CYCLES must be at least 1");
   end

   logic [NPINS-1:0] live;
   logic [NPINS-1:0] sticky_d;
   logic             rearm_kick;
   psd_src_e         src_sel;

   assign src_sel = psd_src_e'(use_sticky);

   psd_sense_vec #(.NPINS(NPINS)) u_sense (
      .pin_level (pin_level),
      .sense_en  (sense_en),
      .sense_inv (sense_inv),
      .live      (live)
   );

   psd_latch_bank #(.NPINS(NPINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (live),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .sticky_q (sticky_o),
      .sticky_d (sticky_d)
   );

   // a clear in sticky mode that leaves bits behind must re-arm the line
   always_comb begin
      rearm_kick = clr_we & (|clr_data) & (src_sel == SRC_STICKY) & (|sticky_d);
   end

   psd_detect_line #(
      .NPINS            (NPINS),
      .REARM_LOW_CYCLES (REARM_LOW_CYCLES)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_sel    (src_sel),
      .live       (live),
      .sticky_d   (sticky_d),
      .rearm_kick (rearm_kick),
      .detect_q   (detect_o),
      .event_q    (event_o)
   );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int NPINS            = 8,
   parameter int REARM_LOW_CYCLES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_level,
   input logic [NPINS-1:0] sense_en,
   input logic [NPINS-1:0] sense_inv,
   input logic             use_sticky,
   input logic             clr_we,
   input logic [NPINS-1:0] clr_data,
   input logic             detect_o,
   input logic             event_o,
   input logic [NPINS-1:0] sticky_o
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_LIVE_REACHES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ((((($past(pin_level) ^ $past(sense_inv)) & $past(sense_en))) & ~sticky_o) == '0)); // R2

   AST_STICKY_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !clr_we) |=> (($past(sticky_o) & ~sticky_o) == '0)); // R3

   AST_EVENT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && event_o) |-> (detect_o && !$past(detect_o))); // R6

   AST_RISE_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $rose(detect_o)) |-> event_o); // R6

   AST_CLEAR_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && clr_we && (|clr_data) && use_sticky) |=> !detect_o); // R7

   if (REARM_LOW_CYCLES >= 2) begin : g_window
      AST_WINDOW_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(clr_we && (|clr_data) && use_sticky) && (|sticky_o)) |=> !detect_o); // R7
   end

endmodule

bind pin_sense_detect psd_checker #(
   .NPINS            (NPINS),
   .REARM_LOW_CYCLES (REARM_LOW_CYCLES)
) u_psd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_level  (pin_level),
   .sense_en   (sense_en),
   .sense_inv  (sense_inv),
   .use_sticky (use_sticky),
   .clr_we     (clr_we),
   .clr_data   (clr_data),
   .detect_o   (detect_o),
   .event_o    (event_o),
   .sticky_o   (sticky_o)
);

// File: tb/pin_sense_detect_bench.sv
module pin_sense_detect_bench;

   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_level = '0;
   logic [NP-1:0] sense_en = '0;
   logic [NP-1:0] sense_inv = '0;
   logic          use_sticky = 1'b0;
   logic          clr_we = 1'b0;
   logic [NP-1:0] clr_data = '0;
   logic          detect_o;
   logic          event_o;
   logic [NP-1:0] sticky_o;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic          det;
      logic          evt;
      logic [NP-1:0] stk;
      string         req;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;

   pin_sense_detect #(.NPINS(NP), .REARM_LOW_CYCLES(2)) u_pin_sense_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_level  (pin_level),
      .sense_en   (sense_en),
      .sense_inv  (sense_inv),
      .use_sticky (use_sticky),
      .clr_we     (clr_we),
      .clr_data   (clr_data),
      .detect_o   (detect_o),
      .event_o    (event_o),
      .sticky_o   (sticky_o)
   );

   task automatic compare(input exp_t e);
      checks++;
      if (detect_o !== e.det || event_o !== e.evt || sticky_o !== e.stk) begin
         fails++;
         $display("FAIL %s: det=%b evt=%b sticky=%h expected det=%b evt=%b sticky=%h",
                  e.req, detect_o, event_o, sticky_o, e.det, e.evt, e.stk);
      end
   endtask

   // monitor: after every rising edge, compare the oldest pending expectation
   always @(posedge clk) begin
      #2;
      if (sb.size() != 0) compare(sb.pop_front());
   end

   // driver: apply inputs at a falling edge and queue what the next edge must give
   task automatic step(input logic [NP-1:0] pins, input logic [NP-1:0] inv,
                       input logic mode, input logic we, input logic [NP-1:0] cd,
                       input logic e_det, input logic e_evt, input logic [NP-1:0] e_stk,
                       input string req);
      exp_t e;
      pin_level  = pins;
      sense_inv  = inv;
      use_sticky = mode;
      clr_we     = we;
      clr_data   = cd;
      e.det = e_det; e.evt = e_evt; e.stk = e_stk; e.req = req;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 5000; c++) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      exp_t r;
      pin_level = 8'hFF;
      sense_en  = 8'hFF;
      repeat (3) @(negedge clk);
      r.det = 1'b0; r.evt = 1'b0; r.stk = '0; r.req = "R8 in reset";
      compare(r);
      pin_level = '0;
      sense_en  = 8'h0F;
      rst_n     = 1'b1;
      @(negedge clk);
      r.req = "R8 after reset";
      compare(r);

      //    pins   inv    mode  we    cd     det   evt   sticky
      step(8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01, "R1 live rise");
      step(8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, "R6 single pulse");
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01, "R2 sticky holds");
      step(8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01, "R1 disabled pin");
      step(8'h00, 8'h02, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h03, "R1 inverted pin");
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h03, "R5 live mode follows");
      step(8'h00, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h02, "R3 clear one bit");
      step(8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h02, "R9 empty write");
      step(8'h04, 8'h00, 1'b0, 1'b1, 8'h06, 1'b1, 1'b1, 8'h04, "R4 set beats clear");
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h04, "R4 bit retained");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h04, "R6 mode change rise");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h04, "R5 sticky mode level");
      step(8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 8'h04, "R9 empty write sticky");
      step(8'h08, 8'h00, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 8'h08, "R7 window cycle 1");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h08, "R7 window cycle 2");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h08, "R7 re-rise event");
      step(8'h00, 8'h00, 1'b1, 1'b1, 8'h08, 1'b0, 1'b0, 8'h00, "R3 clear to empty");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R3 stays empty");
      step(8'h02, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h02, "R5 sticky rise");
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, "R5 back to live");
      step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h02, "R6 rise on reselect");
      step(8'h00, 8'h00, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 8'h00, "R3 live mode clear");

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule